// File: doc/BRIEF.md
# Periodic Channel Retry Controller

This block decides what a host controller's periodic (interrupt) channel does after each bus transaction. Each transaction returns a result code. From that code the block chooses one of four outcomes: finish the transfer, release the channel, retry, or rearm the channel for the next poll. It keeps a 2-bit count of consecutive transaction errors and an ACK-interrupt mask bit. It also issues single-cycle commands that rewind the buffer pointers, release the channel and signal that the transfer is done.

After a retry or a rearm, the block waits for the channel's polling interval less one frame before it issues a re-initialization pulse. It counts that wait in start-of-frame ticks. Three transaction errors in a row release the channel. A NAK clears the error count, but a frame overrun leaves it as it is. The ACK interrupt is unmasked only while an error retry is in progress. Once released, the channel ignores all results until software enables it again.

Top module: `prc_top`

## Requirements
- R1: `res_i` is one-hot coded as bit 0 ACK, bit 1 NAK, bit 2 STALL, bit 3 frame overrun and bit 4 transaction error. A result is taken only in a cycle where `res_valid_i` is high, the channel is enabled and `enable_i` is low. Every output responds on the clock edge that samples the result.
- R2: A STALL pulses `done_o` and `dealloc_o` for one cycle, clears the error count, sets `ack_mask_o` and drops `ch_en_o`.
- R3: A NAK pulses `rewind_o`, sets `ack_mask_o`, clears the error count and schedules a re-initialization.
- R4: A frame overrun pulses `rewind_o`, sets `ack_mask_o`, schedules a re-initialization and leaves the error count unchanged.
- R5: A transaction error with a count below 2 increments the count, pulses `rewind_o`, clears `ack_mask_o` and schedules a re-initialization.
- R6: A transaction error with the count at 2 pulses `dealloc_o` and drops `ch_en_o`. It gives no rewind and no re-initialization, and it leaves the count and the mask unchanged. The count never exceeds 2.
- R7: An ACK clears the error count and sets `ack_mask_o`, with no pulse on any output. A valid result with no bit set changes nothing.
- R8: When several bits are set, the priority is STALL, then NAK or frame overrun, then transaction error, then ACK. NAK together with frame overrun acts as NAK.
- R9: Call the polling interval N. For N of 2 or more, `reinit_o` pulses one cycle after the clock edge that samples the (N-1)th `sof_i` tick following the scheduling result. For N of 0 or 1, `reinit_o` pulses together with `rewind_o`. Without ticks, the wait does not advance.
- R10: While `ch_en_o` is low, results are ignored and no output pulses. A release cancels any pending re-initialization.
- R11: `enable_i` sets `ch_en_o`, clears the count, sets `ack_mask_o` and cancels any pending re-initialization. It takes precedence over a result in the same cycle.
- R12: After reset, `ch_en_o` is 0, the count is 0, `ack_mask_o` is 1 and all pulses are 0.
- R13: A new scheduling result while a wait is pending restarts the wait from the full interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Software channel enable, one-cycle pulse |
| interval_i | input | IVL_W (8) | Polling interval in frames |
| sof_i | input | 1 | Start-of-frame tick |
| res_valid_i | input | 1 | Result strobe |
| res_i | input | 5 | One-hot transaction result |
| ch_en_o | output | 1 | Channel enabled |
| done_o | output | 1 | Transfer-done pulse |
| dealloc_o | output | 1 | Channel release pulse |
| rewind_o | output | 1 | Buffer pointer rewind pulse |
| reinit_o | output | 1 | Channel re-initialization pulse |
| ack_mask_o | output | 1 | ACK interrupt masked when high |
| err_cnt_o | output | CNT_W (2) | Consecutive transaction error count |

## Verification
Some properties are checked on every cycle:
- a done pulse always comes with a release, and never with a rewind;
- a disabled channel stays silent until it is enabled again;
- the error count never passes its limit and only moves up by one on a retry;
- the interval wait moves only on start-of-frame ticks.

Other behaviours depend on a chain of earlier results, so only the bench scenarios show them. These include the exact cycle when re-initialization fires for several intervals, the restart of a pending wait, and the cancellation of a wait by a release or a re-enable. The retry policy across error, NAK and overrun sequences, including mixed-priority codes, is covered the same way.

// File: rtl/prc_pkg.sv
package prc_pkg;
  localparam int RES_W   = 5;
  localparam int RES_ACK = 0;
  localparam int RES_NAK = 1;
  localparam int RES_STL = 2;
  localparam int RES_OVR = 3;
  localparam int RES_XER = 4;

  typedef enum logic [1:0] {
    CNT_HOLD = 2'd0,
    CNT_CLR  = 2'd1,
    CNT_INC  = 2'd2
  } cnt_op_e;

  typedef struct packed {
    logic    done;
    logic    dealloc;
    logic    rewind;
    logic    sched;
    cnt_op_e cnt_op;
    logic    mask_set;
    logic    mask_clr;
  } action_t;
endpackage

// File: rtl/prc_decode.sv
module prc_decode
  import prc_pkg::*;
#(
  parameter int CNT_W     = 2,
  parameter int ERR_LIMIT = 2
) (
  input  logic [RES_W-1:0] res_i,
  input  logic [CNT_W-1:0] cnt_i,
  output action_t          act_o
);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(ERR_LIMIT);

  // fixed priority: STALL > NAK/overrun > xact error > ACK
  always_comb begin
    act_o        = '0;
    act_o.cnt_op = CNT_HOLD;
    if (res_i[RES_STL]) begin
      act_o.done     = 1'b1;
      act_o.dealloc  = 1'b1;
      act_o.cnt_op   = CNT_CLR;
      act_o.mask_set = 1'b1;
    end else if (res_i[RES_NAK] || res_i[RES_OVR]) begin
      act_o.mask_set = 1'b1;
      act_o.rewind   = 1'b1;
      act_o.sched    = 1'b1;
      if (res_i[RES_NAK]) act_o.cnt_op = CNT_CLR;
    end else if (res_i[RES_XER]) begin
      if (cnt_i >= LIMIT) begin
        act_o.dealloc = 1'b1;
      end else begin
        act_o.cnt_op   = CNT_INC;
        act_o.rewind   = 1'b1;
        act_o.mask_clr = 1'b1;
        act_o.sched    = 1'b1;
      end
    end else if (res_i[RES_ACK]) begin
      act_o.cnt_op   = CNT_CLR;
      act_o.mask_set = 1'b1;
    end
  end
endmodule

// File: rtl/prc_err_cnt.sv
module prc_err_cnt
  import prc_pkg::*;
#(
  parameter int CNT_W     = 2,
  parameter int ERR_LIMIT = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  cnt_op_e          op_i,
  input  logic             mask_set_i,
  input  logic             mask_clr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             mask_o
);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(ERR_LIMIT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o  <= '0;
      mask_o <= 1'b1;
    end else if (clr_i) begin
      cnt_o  <= '0;
      mask_o <= 1'b1;
    end else begin
      unique case (op_i)
        CNT_CLR:  cnt_o <= '0;
        CNT_INC:  cnt_o <= cnt_o + 1'b1;
        default:  cnt_o <= cnt_o;
      endcase
      if (mask_set_i)      mask_o <= 1'b1;
      else if (mask_clr_i) mask_o <= 1'b0;
    end
  end

  // R5
  inc_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == CNT_INC && !clr_i) |=> (cnt_o == $past(cnt_o) + 1'b1));
  // R6
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_o <= LIMIT);
endmodule

// File: rtl/prc_sched.sv
module prc_sched #(
  parameter int IVL_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cancel_i,
  input  logic             load_i,
  input  logic [IVL_W-1:0] ivl_i,
  input  logic             sof_i,
  output logic             reinit_o
);
  localparam logic [IVL_W-1:0] ONE = IVL_W'(1);

  logic             pending_q;
  logic [IVL_W-1:0] remain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pending_q <= 1'b0;
      remain_q  <= '0;
      reinit_o  <= 1'b0;
    end else begin
      reinit_o <= 1'b0;
      if (cancel_i) begin
        pending_q <= 1'b0;
      end else if (load_i) begin
        if (ivl_i <= ONE) begin
          reinit_o  <= 1'b1;
          pending_q <= 1'b0;
        end else begin
          pending_q <= 1'b1;
          remain_q  <= ivl_i - ONE;
        end
      end else if (pending_q && sof_i) begin
        if (remain_q == ONE) begin
          reinit_o  <= 1'b1;
          pending_q <= 1'b0;
        end else begin
          remain_q <= remain_q - ONE;
        end
      end
    end
  end

  // R9
  wait_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pending_q && !sof_i && !load_i && !cancel_i) |=> (pending_q && $stable(remain_q) && !reinit_o));
  // R9
  wait_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pending_q && sof_i && !load_i && !cancel_i && remain_q > ONE) |=> (remain_q == $past(remain_q) - ONE));
endmodule

// File: rtl/prc_top.sv
module prc_top
  import prc_pkg::*;
#(
  parameter int IVL_W     = 8,
  parameter int ERR_LIMIT = 2,
  parameter int CNT_W     = $clog2(ERR_LIMIT + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enable_i,
  input  logic [IVL_W-1:0] interval_i,
  input  logic             sof_i,
  input  logic             res_valid_i,
  input  logic [RES_W-1:0] res_i,
  output logic             ch_en_o,
  output logic             done_o,
  output logic             dealloc_o,
  output logic             rewind_o,
  output logic             reinit_o,
  output logic             ack_mask_o,
  output logic [CNT_W-1:0] err_cnt_o
);
  logic    take;
  action_t act_raw, act;

  assign take = res_valid_i && ch_en_o && !enable_i;

  prc_decode #(.CNT_W(CNT_W), .ERR_LIMIT(ERR_LIMIT)) u_dec (
    .res_i (res_i),
    .cnt_i (err_cnt_o),
    .act_o (act_raw)
  );

  always_comb begin
    act = act_raw;
    if (!take) begin
      act        = '0;
      act.cnt_op = CNT_HOLD;
    end
  end

  prc_err_cnt #(.CNT_W(CNT_W), .ERR_LIMIT(ERR_LIMIT)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (enable_i),
    .op_i       (act.cnt_op),
    .mask_set_i (act.mask_set),
    .mask_clr_i (act.mask_clr),
    .cnt_o      (err_cnt_o),
    .mask_o     (ack_mask_o)
  );

  prc_sched #(.IVL_W(IVL_W)) u_sched (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cancel_i (enable_i || act.dealloc),
    .load_i   (act.sched),
    .ivl_i    (interval_i),
    .sof_i    (sof_i),
    .reinit_o (reinit_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ch_en_o   <= 1'b0;
      done_o    <= 1'b0;
      dealloc_o <= 1'b0;
      rewind_o  <= 1'b0;
    end else begin
      done_o    <= act.done;
      dealloc_o <= act.dealloc;
      rewind_o  <= act.rewind;
      if (enable_i)         ch_en_o <= 1'b1;
      else if (act.dealloc) ch_en_o <= 1'b0;
    end
  end

  // R2
  done_dealloc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (dealloc_o && !ch_en_o));
  // R6
  rewind_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rewind_o && dealloc_o));
  // R10
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ch_en_o && !enable_i) |=> (!ch_en_o && !rewind_o && !reinit_o && !dealloc_o));
  // R11
  enable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enable_i |=> (ch_en_o && ack_mask_o && err_cnt_o == '0 && !dealloc_o));
endmodule

// File: tb/tb_prc_top.sv
module tb_prc_top;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 18;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enable = 1'b0;
  logic [7:0] interval = 8'd1;
  logic       sof = 1'b0;
  logic       res_valid = 1'b0;
  logic [4:0] res = '0;
  logic       ch_en, done, dealloc, rewind, reinit, ack_mask;
  logic [1:0] err_cnt;

  int n_vec = 0;
  int n_err = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prc_top dut (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(enable), .interval_i(interval),
    .sof_i(sof), .res_valid_i(res_valid), .res_i(res), .ch_en_o(ch_en),
    .done_o(done), .dealloc_o(dealloc), .rewind_o(rewind), .reinit_o(reinit),
    .ack_mask_o(ack_mask), .err_cnt_o(err_cnt)
  );

  // {en_first, res[4:0], cnt, mask, rewind, reinit, done, dealloc, ch_en}
  // res bits: 4 xact err, 3 overrun, 2 STALL, 1 NAK, 0 ACK
  localparam logic [13:0] VEC [NVEC] = '{
    {1'b1, 5'b10000, 2'd1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1}, // R11 R5
    {1'b0, 5'b10000, 2'd2, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1}, // R5
    {1'b0, 5'b00010, 2'd0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1}, // R3
    {1'b0, 5'b10000, 2'd1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1}, // R5
    {1'b0, 5'b01000, 2'd1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1}, // R4
    {1'b0, 5'b10000, 2'd2, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1}, // R5
    {1'b0, 5'b00001, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1}, // R7
    {1'b0, 5'b01010, 2'd0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1}, // R8
    {1'b0, 5'b10001, 2'd1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1}, // R8
    {1'b0, 5'b10110, 2'd0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0}, // R2 R8
    {1'b0, 5'b00001, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R10
    {1'b1, 5'b10000, 2'd1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1}, // R11 R5
    {1'b0, 5'b10000, 2'd2, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1}, // R5
    {1'b0, 5'b10000, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0}, // R6
    {1'b0, 5'b10000, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R10
    {1'b1, 5'b00001, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1}, // R11 R7
    {1'b0, 5'b00000, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1}, // R7
    {1'b0, 5'b01000, 2'd0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1}  // R4 R1
  };

  function automatic string vtag(int i);
    case (i)
      0, 11:   return "R11/R5";
      1, 3, 5, 12: return "R5";
      2:       return "R3";
      4, 17:   return "R4";
      6, 16:   return "R7";
      7, 8:    return "R8";
      9:       return "R2";
      10, 14:  return "R10";
      13:      return "R6";
      default: return "R11/R7";
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] outs();
    return {err_cnt, ack_mask, rewind, reinit, done, dealloc, ch_en};
  endfunction

  task automatic pulse_enable();
    @(negedge clk); enable = 1'b1;
    @(negedge clk); enable = 1'b0;
  endtask

  task automatic apply(logic [4:0] r);
    @(negedge clk); res_valid = 1'b1; res = r;
    @(negedge clk); res_valid = 1'b0; res = '0;
  endtask

  task automatic tick();
    @(negedge clk); sof = 1'b1;
    @(negedge clk); sof = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_err++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12 reset state
    chk("R12", {24'd0, outs()}, {24'd0, 2'd0, 1'b1, 5'b0});
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12", {24'd0, outs()}, {24'd0, 2'd0, 1'b1, 5'b0});

    for (int i = 0; i < NVEC; i++) begin
      if (VEC[i][13]) pulse_enable();
      apply(VEC[i][12:8]);
      chk(vtag(i), {24'd0, outs()}, {24'd0, VEC[i][7:0]});
    end

    // R9 interval 4: reinit after third tick
    interval = 8'd4;
    apply(5'b00010);
    chk("R9 load", {31'd0, reinit}, 32'd0);
    tick(); chk("R9 tick1", {31'd0, reinit}, 32'd0);
    tick(); chk("R9 tick2", {31'd0, reinit}, 32'd0);
    repeat (3) @(negedge clk);
    chk("R9 no tick", {31'd0, reinit}, 32'd0);
    tick(); chk("R9 tick3", {31'd0, reinit}, 32'd1);
    @(negedge clk); chk("R9 one pulse", {31'd0, reinit}, 32'd0);

    // R9 interval 0 acts as immediate
    interval = 8'd0;
    apply(5'b01000);
    chk("R9 ivl0", {30'd0, rewind, reinit}, 32'd3);

    // R13 restart
    interval = 8'd3;
    apply(5'b00010);
    tick(); chk("R13 t1", {31'd0, reinit}, 32'd0);
    apply(5'b00010);
    tick(); chk("R13 restart", {31'd0, reinit}, 32'd0);
    tick(); chk("R13 fire", {31'd0, reinit}, 32'd1);

    // R11 enable cancels pending wait and clears count
    apply(5'b10000);
    chk("R5 pre", {30'd0, err_cnt}, 32'd1);
    pulse_enable();
    chk("R11 clear", {29'd0, err_cnt, ack_mask}, 32'd1);
    tick(); tick(); tick();
    chk("R11 cancel", {31'd0, reinit}, 32'd0);

    // R10 release cancels pending wait
    apply(5'b00010);
    apply(5'b00100);
    chk("R2 stall", {30'd0, done, ch_en}, 32'd2);
    tick(); tick(); tick();
    chk("R10 cancel", {31'd0, reinit}, 32'd0);

    // R11 enable wins over same-cycle result
    @(negedge clk); enable = 1'b1; res_valid = 1'b1; res = 5'b00100;
    @(negedge clk); enable = 1'b0; res_valid = 1'b0; res = '0;
    chk("R11 prio", {29'd0, ch_en, dealloc, done}, 32'd4);

    // R1 no strobe: result ignored
    @(negedge clk); res = 5'b00100;
    @(negedge clk); res = '0;
    chk("R1 strobe", {30'd0, ch_en, dealloc}, 32'd2);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end
endmodule